// File: doc/BRIEF.md
# Sigma-Delta ADC Channel Setup Sequencer

This block opens a conversion on one input channel of an external sigma-delta converter through a byte-oriented SPI link. It also checks that the converter really took its configuration. The block takes one request: a channel, a setup byte and an optional power-up flag. It then clocks out a fixed series of command and value bytes. These write the setup register, then the clock register, then the test register. Next the block reads the 16-bit data register once and throws the result away. That read is done only to clear the converter's ready flag. Last, the block reads the setup register back and compares it with the byte it wrote.

When the power-up flag is set, the block first sends a run of all-ones bytes so that the converter's serial port returns to a known state. The mode field of the setup byte is then forced to self-calibration. A request is a valid/ready handshake. The block raises `req_ready` only while it is idle. A requester that sees `req_ready` low keeps `req_valid` and its fields steady until a cycle in which both are high. Only that cycle is a transfer. Results come out on plain status pins: a one-cycle `done` strobe, an `ok` bit and the byte that was read back.

Top module: `adc_setup_seq`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sclk` is high, `done` is low and `req_ready` is high.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle until `done`. Any `req_valid` raised while the block is busy has no effect.
- R3: A normal request sends exactly eleven bytes, in this order: setup-write command, setup byte, clock-write command, 0x0C, test-write command, 0x00, data-read command, two filler bytes 0xFF, setup-read command, one filler byte 0xFF.
- R4: A power-up request first sends seven 0xFF bytes and then the eleven-byte series. In that series, setup-byte bits [7:6] are replaced by 01 (self-calibration) and bits [5:0] are passed through unchanged.
- R5: Each command byte is {0, reg[2:0], rd, 0, chan[1:0]}. The register codes are: setup 1, clock 2, data 3, test 4. `rd` is 1 for reads. So the commands are 0x10|ch, 0x20|ch, 0x40|ch, 0x38|ch and 0x18|ch.
- R6: `readback` equals the byte received during the final filler byte. `ok` is 1 exactly when that byte equals the setup byte as it was sent.
- R7: `done` is high for exactly one cycle per accepted request. `ok` and `readback` hold their values until the next `done`.
- R8: `spi_cs_n` goes low before the first byte and stays low through the last byte. It is high in the `done` cycle and whenever the block is idle.
- R9: The SPI link runs in mode 3. SCLK idles high. Bits go out MSB first, and MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge. Each SCLK half-period lasts HALF_DIV clock cycles.
- R10: The two data bytes read back have no influence on `ok` or `readback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_chan | input | 2 | Converter channel number |
| req_setup | input | 8 | Setup byte: mode[7:6], gain[5:3], unipolar[2], buffer[1], filter sync[0] |
| req_power_up | input | 1 | Send the resync burst and force self-calibration |
| done | output | 1 | One-cycle completion strobe |
| ok | output | 1 | Readback matched the setup byte sent |
| readback | output | 8 | Setup byte read back from the converter |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |

## Verification
The bench builds the block with HALF_DIV=2 and SYNC_BYTES=7. The short half-period lets a power-up request with its full seven-byte resync burst run in a few hundred cycles. This allows normal and power-up requests on all four channels, readback matches and mismatches, and a request raised mid-sequence to be checked within the cycle limit. The modelled converter sends junk in the discarded data bytes, so any leak of those bytes into the result would show.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned CFG_STEPS = 11;

  localparam logic [2:0] REG_SETUP = 3'd1;
  localparam logic [2:0] REG_CLOCK = 3'd2;
  localparam logic [2:0] REG_DATA  = 3'd3;
  localparam logic [2:0] REG_TEST  = 3'd4;

  localparam logic [7:0] CLOCK_VAL  = 8'h0C;
  localparam logic [7:0] TEST_VAL   = 8'h00;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [1:0] MODE_SELFCAL = 2'b01;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_WAIT
  } seq_state_e;

  function automatic logic [7:0] cmd_byte(input logic [2:0] regsel,
                                          input logic rd,
                                          input logic [1:0] ch);
    return {1'b0, regsel, rd, 1'b0, ch};
  endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       busy,
  output logic       byte_done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi
);
  localparam int unsigned CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      byte_done <= 1'b0;
      rx        <= '0;
      sclk      <= 1'b1;
      mosi      <= 1'b1;
      cnt       <= '0;
      bitn      <= '0;
      sh        <= '0;
    end else begin
      byte_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= tx;
          mosi <= tx[7];
          sclk <= 1'b0;
          cnt  <= '0;
          bitn <= '0;
        end
      end else if (cnt == CNT_LAST) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else if (bitn == 3'd7) begin
          busy      <= 1'b0;
          byte_done <= 1'b1;
        end else begin
          bitn <= bitn + 3'd1;
          sclk <= 1'b0;
          mosi <= sh[6];
          sh   <= {sh[6:0], 1'b0};
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R9: clock idles high between bytes
  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

  // R9: data never moves on the rising edge
  p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned SYNC_BYTES = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] chan,
  input  logic [7:0] setup,
  input  logic       power_up,
  input  logic       byte_done,
  input  logic [7:0] rx,
  output logic       byte_start,
  output logic [7:0] tx,
  output logic       cs_n,
  output logic       idle,
  output logic       done,
  output logic       ok,
  output logic [7:0] readback
);
  localparam int unsigned TOTAL = SYNC_BYTES + CFG_STEPS;
  localparam int unsigned IW    = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] IDX_FIRST_CFG = IW'(SYNC_BYTES);
  localparam logic [IW-1:0] IDX_LAST      = IW'(TOTAL - 1);

  seq_state_e    state;
  logic [IW-1:0] idx;
  logic [IW-1:0] step;
  logic [1:0]    chan_l;
  logic [7:0]    setup_l;
  logic          pu_l;
  logic [7:0]    setup_sent;

  assign setup_sent = pu_l ? {MODE_SELFCAL, setup_l[5:0]} : setup_l;
  assign step       = idx - IDX_FIRST_CFG;
  assign idle       = (state == SQ_IDLE);

  always_comb begin
    tx = FILL_BYTE;
    if (idx >= IDX_FIRST_CFG) begin
      case (step)
        IW'(0):  tx = cmd_byte(REG_SETUP, 1'b0, chan_l);
        IW'(1):  tx = setup_sent;
        IW'(2):  tx = cmd_byte(REG_CLOCK, 1'b0, chan_l);
        IW'(3):  tx = CLOCK_VAL;
        IW'(4):  tx = cmd_byte(REG_TEST, 1'b0, chan_l);
        IW'(5):  tx = TEST_VAL;
        IW'(6):  tx = cmd_byte(REG_DATA, 1'b1, chan_l);
        IW'(9):  tx = cmd_byte(REG_SETUP, 1'b1, chan_l);
        default: tx = FILL_BYTE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      idx        <= '0;
      chan_l     <= '0;
      setup_l    <= '0;
      pu_l       <= 1'b0;
      cs_n       <= 1'b1;
      byte_start <= 1'b0;
      done       <= 1'b0;
      ok         <= 1'b0;
      readback   <= '0;
    end else begin
      byte_start <= 1'b0;
      done       <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            chan_l  <= chan;
            setup_l <= setup;
            pu_l    <= power_up;
            idx     <= power_up ? '0 : IDX_FIRST_CFG;
            cs_n    <= 1'b0;
            state   <= SQ_LAUNCH;
          end
        end
        SQ_LAUNCH: begin
          byte_start <= 1'b1;
          state      <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (byte_done) begin
            if (idx == IDX_LAST) begin
              readback <= rx;
              ok       <= (rx == setup_sent);
              done     <= 1'b1;
              cs_n     <= 1'b1;
              state    <= SQ_IDLE;
            end else begin
              idx   <= idx + IW'(1);
              state <= SQ_LAUNCH;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R7: completion strobe lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: results stay put between completions
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(readback) && $stable(ok));

endmodule

// File: rtl/adc_setup_seq.sv
module adc_setup_seq #(
  parameter int unsigned HALF_DIV   = 4,
  parameter int unsigned SYNC_BYTES = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_chan,
  input  logic [7:0] req_setup,
  input  logic       req_power_up,
  output logic       done,
  output logic       ok,
  output logic [7:0] readback,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic       byte_start;
  logic       byte_done;
  logic       eng_busy;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;
  logic       seq_idle;

  assign req_ready = seq_idle;

  adc_seq_ctrl #(.SYNC_BYTES(SYNC_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (req_valid && req_ready),
    .chan       (req_chan),
    .setup      (req_setup),
    .power_up   (req_power_up),
    .byte_done  (byte_done),
    .rx         (rx_byte),
    .byte_start (byte_start),
    .tx         (tx_byte),
    .cs_n       (spi_cs_n),
    .idle       (seq_idle),
    .done       (done),
    .ok         (ok),
    .readback   (readback)
  );

  spi_byte_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (byte_start),
    .tx        (tx_byte),
    .miso      (spi_miso),
    .busy      (eng_busy),
    .byte_done (byte_done),
    .rx        (rx_byte),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi)
  );

  // R8: chip select held across every byte
  p_cs_during_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !spi_cs_n);

  // R8: chip select released when the result is reported
  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);

  // R2: an accepted request drops ready next cycle
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/adc_setup_seq_bench.sv
module adc_setup_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_chan = '0;
  logic [7:0] req_setup = '0;
  logic       req_power_up = 1'b0;
  logic       done, ok;
  logic [7:0] readback;
  logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  adc_setup_seq #(.HALF_DIV(2), .SYNC_BYTES(7)) u_adc_setup_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_setup(req_setup), .req_power_up(req_power_up),
    .done(done), .ok(ok), .readback(readback), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard of expected MOSI bytes and converter model
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] reply_byte = 8'h00;
  int         n_total = 0;
  int         byte_i = 0;
  logic [2:0] bit_i = '0;
  logic [7:0] slave_rx = '0;
  logic [7:0] cur_out;

  assign cur_out  = (byte_i == n_total - 1) ? reply_byte : 8'hA5;
  assign spi_miso = cur_out[3'd7 - bit_i];

  always @(negedge spi_cs_n) begin
    byte_i = 0;
    bit_i  = '0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      logic [7:0] got;
      got = {slave_rx[6:0], spi_mosi};
      slave_rx = got;
      bit_i = bit_i + 3'd1;
      if (bit_i == 3'd0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 extra byte", got, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, got, e);
        end
        byte_i++;
      end
    end
  end

  task automatic push(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic run_req(input logic [1:0] ch, input logic [7:0] setup,
                         input bit pu, input logic [7:0] reply, input bit poke_busy);
    logic [7:0] sent;
    bit exp_ok;
    sent = pu ? {2'b01, setup[5:0]} : setup;
    exp_ok = (reply == sent);
    if (pu) for (int k = 0; k < 7; k++) push(8'hFF, "R4 sync burst");
    push({4'h1, 2'b00, ch}, "R5 setup write cmd");
    push(sent, pu ? "R4 setup byte self-cal" : "R3 setup byte");
    push({4'h2, 2'b00, ch}, "R5 clock write cmd");
    push(8'h0C, "R3 clock value");
    push({4'h4, 2'b00, ch}, "R5 test write cmd");
    push(8'h00, "R3 test value");
    push({4'h3, 2'b10, ch}, "R5 data read cmd");
    push(8'hFF, "R3 filler");
    push(8'hFF, "R3 filler");
    push({4'h1, 2'b10, ch}, "R5 setup read cmd");
    push(8'hFF, "R3 filler");
    n_total = pu ? 18 : 11;
    reply_byte = reply;

    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_setup = setup; req_power_up = pu;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
    check(spi_cs_n == 1'b0, "R8 cs asserted", spi_cs_n, 0);
    if (poke_busy) begin
      req_valid = 1'b1; req_chan = ~ch; req_setup = ~setup;
      repeat (30) @(negedge clk);
      check(req_ready == 1'b0, "R2 busy ignores valid", req_ready, 0);
      req_valid = 1'b0;
    end
    while (!done) begin
      if (!req_ready && !spi_sclk) check(spi_cs_n == 1'b0, "R8 cs held", spi_cs_n, 0);
      @(negedge clk);
    end
    check(ok == exp_ok, "R6 ok", ok, exp_ok);
    check(readback == reply, "R6 R10 readback", readback, reply);
    check(spi_cs_n == 1'b1, "R8 cs released at done", spi_cs_n, 1);
    check(exp_q.size() == 0, "R3 byte count", exp_q.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    repeat (20) @(negedge clk);
    check(ok == exp_ok && readback == reply, "R7 results held", readback, reply);
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b1, "R8 R9 idle lines", {spi_cs_n, spi_sclk}, 3);
    check(exp_q.size() == 0, "R2 no extra bytes", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 cs reset", spi_cs_n, 1);
    check(spi_sclk == 1'b1, "R1 sclk reset", spi_sclk, 1);
    check(done == 1'b0, "R1 done reset", done, 0);
    check(req_ready == 1'b1, "R1 ready reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 R6: normal request, converter echoes the setup byte
    run_req(2'd0, 8'h2A, 1'b0, 8'h2A, 1'b0);
    // R6: mismatching readback
    run_req(2'd1, 8'h22, 1'b0, 8'h00, 1'b0);
    // R4: power-up path, reply carries self-cal mode
    run_req(2'd3, 8'hA7, 1'b1, 8'h67, 1'b0);
    // R4: power-up, reply with original mode mismatches
    run_req(2'd2, 8'h13, 1'b1, 8'h13, 1'b0);
    // R2 R5: valid raised while busy, channel 2
    run_req(2'd2, 8'hC5, 1'b0, 8'hC5, 1'b1);
    finish_run();
  end
endmodule